// File: doc/BRIEF.md
# Two-Channel Prescaled Bit Error Totalizer

This block counts bit errors seen on two fixed-value measurement lanes of a parallel receive word. It is built for a word clock too fast for a wide adder. Each lane compares its received bit with the value that lane should carry. The mismatch strobe is the clock enable of a three-flip-flop Johnson ring, which is the only logic that works at the full word rate.

A slow phase strobe marks one cycle in every four. On that cycle, each ring state is decoded to a number from 0 to 5. The previous decoded sample is subtracted modulo 6, which gives the lane's error count for the interval. Both lane counts are added into a wide saturating accumulator with a sticky overflow flag. Software raises a capture request to copy the running total into a held read register, and a clear request to restart the count. Both requests act only on a slow phase cycle.

Top module: `err_totalizer`

## Requirements
- R1: Lane A watches `rx_word[8]` and lane B watches `rx_word[15]`. With `invert` low, an error is bit 8 equal to 1 or bit 15 equal to 0. With `invert` high, both expected values are complemented.
- R2: Each lane's Johnson ring advances on every fast clock edge at which that lane's error strobe is high, and holds its state otherwise. The ring wraps after 6 steps, so up to 4 errors per lane per interval are counted exactly.
- R3: At a slow phase edge, a lane's interval count is the number of its errors at the edges from the previous slow phase edge (inclusive) to this one (exclusive).
- R4: The interval counts of both lanes are added into the accumulator at the same slow phase edge.
- R5: The accumulator stops at its maximum value 2^ACC_W-1 and does not wrap. A sticky overflow flag is set when a sum would exceed that value.
- R6: A clear request with the slow phase zeroes the accumulator and the overflow flag. Errors before that edge are discarded. The Johnson rings keep running, so errors after the clear are counted exactly.
- R7: A capture request with the slow phase loads `total` and `ovf` with the accumulator value and overflow flag after this interval's addition. At every other edge, `total` and `ovf` hold.
- R8: When a capture and a clear come on the same slow phase edge, the capture gets the sum that includes this interval, and the accumulator starts again from zero.
- R9: A clear or capture request raised while `slow_en` is low has no effect on the count or on the outputs.
- R10: After reset, `total` is 0 and `ovf` is 0. Reset takes effect at once and is released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast word clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| slow_en | input | 1 | High one cycle in every four; sample and accumulate phase |
| rx_word | input | 16 | Received parallel word |
| invert | input | 1 | Complements the expected lane values |
| clr | input | 1 | Clear request, acts with slow_en |
| latch | input | 1 | Capture request, acts with slow_en |
| total | output | ACC_W | Captured error total |
| ovf | output | 1 | Captured overflow flag |

## Verification
Two functions can fall on the same slow phase edge. The first pair is a capture and a clear. The bench raises both together and expects the read value to include that interval's errors, with the next capture counting only newer errors. The second pair is saturation and a clear: the bench drives four errors on each lane for as many intervals as it takes to pin the reduced-width accumulator, then raises capture and clear together. It expects the pinned total with the overflow flag set, and after that a clean restart.

// File: rtl/errtot_pkg.sv
package errtot_pkg;

  // number of measurement lanes fed into the totalizer
  parameter int unsigned NUM_CH = 2;

  // commands that act on the slow phase only
  typedef struct packed {
    logic take;   // sample rings and accumulate
    logic wipe;   // restart the accumulator
    logic grab;   // copy the sum into the read register
  } slow_cmd_t;

endpackage

// File: rtl/errtot_rst_sync.sv
module errtot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_ni = sh_q[STAGES-1];

endmodule

// File: rtl/errtot_jcnt.sv
module errtot_jcnt #(
  parameter int unsigned JC_FF = 3
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             en,
  output logic [JC_FF-1:0] q
);

  logic [JC_FF-1:0] q_d;

  // twisted-ring step, gated by the error strobe
  always_comb begin
    if (en) q_d = {q[JC_FF-2:0], ~q[JC_FF-1]};
    else    q_d = q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= q_d;
  end

endmodule

// File: rtl/errtot_delta.sv
module errtot_delta #(
  parameter int unsigned JC_FF = 3,
  localparam int unsigned MOD  = 2 * JC_FF,
  localparam int unsigned DW   = $clog2(MOD)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             take,
  input  logic [JC_FF-1:0] ring,
  output logic [DW-1:0]    delta
);

  logic [DW-1:0] cur;
  logic [DW-1:0] prev_q;
  logic [DW-1:0] prev_d;
  int            ones;
  int            diff;

  // ring state to binary: count of ones, folded on the top bit
  always_comb begin
    ones = 0;
    for (int i = 0; i < int'(JC_FF); i++) begin
      ones = ones + int'(ring[i]);
    end
    if (ring[JC_FF-1]) cur = DW'(int'(MOD) - ones);
    else               cur = DW'(ones);
  end

  // modulo difference against the previous sample
  always_comb begin
    diff = int'(cur) - int'(prev_q);
    if (diff < 0) diff = diff + int'(MOD);
    delta = DW'(diff);
  end

  always_comb begin
    if (take) prev_d = cur;
    else      prev_d = prev_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

endmodule

// File: rtl/errtot_acc.sv
module errtot_acc
  import errtot_pkg::*;
#(
  parameter int unsigned ACC_W = 24,
  parameter int unsigned IN_W  = 3,
  parameter int unsigned NCH   = 2
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  slow_cmd_t                 cmd,
  input  logic [NCH-1:0][IN_W-1:0]  d_vec,
  output logic [ACC_W-1:0]          acc_q,
  output logic                      acc_ovf,
  output logic [ACC_W-1:0]          rd_q,
  output logic                      rd_ovf
);

  localparam logic [ACC_W-1:0] MAXV = {ACC_W{1'b1}};

  logic [ACC_W:0]   wide;
  logic [ACC_W-1:0] sum_sat;
  logic             ovf_new;
  logic [ACC_W-1:0] acc_d;
  logic             ovf_d;
  logic [ACC_W-1:0] rd_d;
  logic             rd_ovf_d;

  always_comb begin
    wide = {1'b0, acc_q};
    for (int g = 0; g < int'(NCH); g++) begin
      wide = wide + (ACC_W+1)'(d_vec[g]);
    end
    if (wide[ACC_W]) begin
      sum_sat = MAXV;
      ovf_new = 1'b1;
    end else begin
      sum_sat = wide[ACC_W-1:0];
      ovf_new = acc_ovf;
    end
  end

  always_comb begin
    acc_d    = acc_q;
    ovf_d    = acc_ovf;
    rd_d     = rd_q;
    rd_ovf_d = rd_ovf;
    if (cmd.take) begin
      if (cmd.grab) begin
        rd_d     = sum_sat;
        rd_ovf_d = ovf_new;
      end
      if (cmd.wipe) begin
        acc_d = '0;
        ovf_d = 1'b0;
      end else begin
        acc_d = sum_sat;
        ovf_d = ovf_new;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      acc_ovf <= 1'b0;
      rd_q    <= '0;
      rd_ovf  <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      acc_ovf <= ovf_d;
      rd_q    <= rd_d;
      rd_ovf  <= rd_ovf_d;
    end
  end

endmodule

// File: rtl/err_totalizer.sv
module err_totalizer
  import errtot_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BIT_LO = 8,
  parameter int unsigned BIT_HI = 15,
  parameter int unsigned JC_FF  = 3,
  parameter int unsigned ACC_W  = 24,
  localparam int unsigned DW    = $clog2(2 * JC_FF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_en,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              invert,
  input  logic              clr,
  input  logic              latch,
  output logic [ACC_W-1:0]  total,
  output logic              ovf
);

  logic                            rst_ni;
  logic [NUM_CH-1:0]               err_vec;
  logic [NUM_CH-1:0][JC_FF-1:0]    jq;
  logic [NUM_CH-1:0][DW-1:0]       d_vec;
  logic [ACC_W-1:0]                acc_q;
  logic                            acc_ovf;
  slow_cmd_t                       cmd;

  errtot_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  // lane A expects 0, lane B expects 1; invert flips both
  always_comb begin
    err_vec[0] = rx_word[BIT_LO] ^ invert;
    err_vec[1] = rx_word[BIT_HI] ^ ~invert;
  end

  always_comb begin
    cmd.take = slow_en;
    cmd.wipe = clr;
    cmd.grab = latch;
  end

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_lane
    errtot_jcnt #(.JC_FF(JC_FF)) u_ring (
      .clk    (clk),
      .rst_ni (rst_ni),
      .en     (err_vec[g]),
      .q      (jq[g])
    );
    errtot_delta #(.JC_FF(JC_FF)) u_delta (
      .clk    (clk),
      .rst_ni (rst_ni),
      .take   (slow_en),
      .ring   (jq[g]),
      .delta  (d_vec[g])
    );
  end

  errtot_acc #(.ACC_W(ACC_W), .IN_W(DW), .NCH(NUM_CH)) u_acc (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .cmd     (cmd),
    .d_vec   (d_vec),
    .acc_q   (acc_q),
    .acc_ovf (acc_ovf),
    .rd_q    (total),
    .rd_ovf  (ovf)
  );

endmodule

// File: rtl/errtot_chk.sv
module errtot_chk #(
  parameter int unsigned ACC_W = 24,
  parameter int unsigned JC_FF = 3
) (
  input logic                   clk,
  input logic                   rst_ni,
  input logic                   slow_en,
  input logic                   clr,
  input logic                   latch,
  input logic [1:0]             err_vec,
  input logic [1:0][JC_FF-1:0]  jq,
  input logic [ACC_W-1:0]       acc_q,
  input logic                   acc_ovf,
  input logic [ACC_W-1:0]       total,
  input logic                   ovf
);

  for (genvar g = 0; g < 2; g++) begin : g_ring
    // R2: a ring holds without an error and moves with one
    a_r2_ring_hold: assert property (@(posedge clk) disable iff (!rst_ni)
      !err_vec[g] |=> $stable(jq[g]));
    a_r2_ring_move: assert property (@(posedge clk) disable iff (!rst_ni)
      err_vec[g] |=> !$stable(jq[g]));
  end

  // R5: a set overflow flag means the accumulator is pinned at its top
  a_r5_pinned: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_ovf |-> (acc_q == {ACC_W{1'b1}}));

  // R6: clear on the slow phase empties the accumulator
  a_r6_wipe: assert property (@(posedge clk) disable iff (!rst_ni)
    (slow_en && clr) |=> (acc_q == '0) && !acc_ovf);

  // R7: outputs move only on a slow-phase capture
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !(slow_en && latch) |=> $stable(total) && $stable(ovf));

  // R9: a clear off the slow phase leaves the accumulator alone
  a_r9_no_wipe: assert property (@(posedge clk) disable iff (!rst_ni)
    (!slow_en) |=> $stable(acc_q) && $stable(acc_ovf));

endmodule

bind err_totalizer errtot_chk #(.ACC_W(ACC_W), .JC_FF(JC_FF)) u_chk (
  .clk     (clk),
  .rst_ni  (rst_ni),
  .slow_en (slow_en),
  .clr     (clr),
  .latch   (latch),
  .err_vec (err_vec),
  .jq      (jq),
  .acc_q   (acc_q),
  .acc_ovf (acc_ovf),
  .total   (total),
  .ovf     (ovf)
);

// File: tb/err_totalizer_test.sv
module err_totalizer_test;

  localparam int unsigned ACC_W = 10;
  localparam int          MAXV  = (1 << ACC_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             slow_en;
  logic [15:0]      rx_word;
  logic             invert;
  logic             clr;
  logic             latch;
  logic [ACC_W-1:0] total;
  logic             ovf;

  int total_chk = 0;
  int bad_chk   = 0;
  int cyc       = 0;

  // reference state
  int m_pend = 0;
  int m_acc  = 0;
  int m_ovf  = 0;
  int e_tot  = 0;
  int e_ovf  = 0;
  string tag = "R10";

  err_totalizer #(.ACC_W(ACC_W)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .slow_en (slow_en),
    .rx_word (rx_word),
    .invert  (invert),
    .clr     (clr),
    .latch   (latch),
    .total   (total),
    .ovf     (ovf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp_v);
    total_chk++;
    if (act != exp_v) begin
      bad_chk++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp_v, cyc);
    end
  endtask

  // lane error from the R1 rule, applied to the driven bits
  function automatic int lane_errs(input logic [15:0] w, input logic inv);
    int a;
    int b;
    a = (w[8]  != inv)  ? 1 : 0;
    b = (w[15] != ~inv) ? 1 : 0;
    return a + b;
  endfunction

  // one fast cycle: drive at negedge, update the model at posedge, check at next negedge
  task automatic step(input bit ea, input bit eb, input bit inv, input bit c, input bit l);
    logic [15:0] w;
    bit          s;
    int          sum;
    int          n;
    w      = 16'($urandom);
    w[8]   = ea ^ inv;
    w[15]  = eb ^ ~inv;
    s      = (cyc % 4) == 0;
    rx_word = w;
    invert  = inv;
    slow_en = s;
    clr     = c;
    latch   = l;
    n = lane_errs(w, inv);
    @(posedge clk);
    if (s) begin
      sum = m_acc + m_pend;
      m_pend = n;
      if (sum > MAXV) begin
        sum = MAXV;
        m_ovf = 1;
      end
      if (l) begin
        e_tot = sum;
        e_ovf = m_ovf;
      end
      if (c) begin
        m_acc = 0;
        m_ovf = 0;
      end else begin
        m_acc = sum;
      end
    end else begin
      m_pend = m_pend + n;
    end
    cyc++;
    @(negedge clk);
    check({tag, " total"}, int'(total), e_tot);
    check({tag, " ovf"}, int'(ovf), e_ovf);
  endtask

  // four cycles starting on a slow phase; na/nb errors on the first cycles
  task automatic interval(input int na, input int nb, input bit inv, input bit c, input bit l);
    for (int k = 0; k < 4; k++) begin
      step(k < na, k < nb, inv, (k == 0) && c, (k == 0) && l);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad_chk++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h0c1a_5eed));
    rst_n   = 1'b0;
    slow_en = 1'b0;
    rx_word = 16'h8000;
    invert  = 1'b0;
    clr     = 1'b0;
    latch   = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs idle in reset
    tag = "R10";
    check("R10 total in reset", int'(total), 0);
    check("R10 ovf in reset", int'(ovf), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 total after release", int'(total), 0);
    cyc = 0;

    // R1 R3: lane A only, three errors, captured next slow phase
    tag = "R1 R3 laneA";
    interval(3, 0, 1'b0, 1'b0, 1'b0);
    interval(0, 0, 1'b0, 1'b0, 1'b1);
    check("R3 laneA count", e_tot, 3);

    // R1: lane B only with inversion
    tag = "R1 laneB inverted";
    interval(0, 2, 1'b1, 1'b0, 1'b0);
    interval(0, 0, 1'b1, 1'b0, 1'b1);
    check("R1 inverted count", e_tot, 5);

    // R2 R4: four errors on both lanes, rings wrap
    tag = "R2 R4 full rate";
    for (int i = 0; i < 6; i++) interval(4, 4, 1'b0, 1'b0, 1'b0);
    interval(0, 0, 1'b0, 1'b0, 1'b1);
    check("R4 both lanes summed", e_tot, 53);

    // R9: requests off the slow phase ignored
    tag = "R9 off-phase requests";
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    interval(0, 0, 1'b0, 1'b0, 1'b1);
    check("R9 no clear took effect", e_tot, 54);

    // R8: capture and clear together
    tag = "R8 capture with clear";
    interval(2, 1, 1'b0, 1'b0, 1'b0);
    interval(1, 1, 1'b0, 1'b1, 1'b1);
    check("R8 capture includes interval", e_tot, 57);
    interval(0, 0, 1'b0, 1'b0, 1'b1);
    check("R8 restart counts newer only", e_tot, 2);

    // R6: clear alone drops earlier errors, later ones counted exactly
    tag = "R6 clear";
    interval(3, 3, 1'b0, 1'b0, 1'b0);
    interval(1, 2, 1'b0, 1'b1, 1'b0);
    interval(0, 0, 1'b0, 1'b0, 1'b1);
    check("R6 after clear", e_tot, 3);

    // R3 R4 R7: random traffic and requests
    tag = "R3 R4 R7 random";
    for (int i = 0; i < 700; i++) begin
      bit inv;
      inv = ($urandom % 8) == 0 ? ~invert : invert;
      for (int k = 0; k < 4; k++) begin
        step(($urandom % 3) == 0, ($urandom % 4) == 0, inv,
             ($urandom % 29) == 0, ($urandom % 3) == 0);
      end
    end

    // R5: saturate the accumulator, then read and clear together
    tag = "R5 saturation";
    interval(0, 0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 135; i++) interval(4, 4, 1'b0, 1'b0, 1'b0);
    interval(0, 0, 1'b0, 1'b1, 1'b1);
    check("R5 pinned total", e_tot, MAXV);
    check("R5 overflow flag", e_ovf, 1);
    tag = "R6 after saturation";
    interval(2, 2, 1'b0, 1'b0, 1'b0);
    interval(0, 0, 1'b0, 1'b0, 1'b1);
    check("R6 clean restart", e_tot, 4);
    check("R6 flag cleared", e_ovf, 0);

    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

endmodule